// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resizes one line of pixels along the horizontal axis. It first collects the whole source line into an internal line store. It then walks a fixed-point sampling position across that line and emits one destination pixel for each step. Every destination pixel is a 7-tap weighted sum of neighbouring source pixels. The weights come from one of 16 filter phases, chosen by the fractional part of the position.

Only nine phase sets are held in the weight bank. The upper seven phases reuse the lower ones with their tap order reversed. Software loads the weights over a plain 32-bit write port, and each phase takes three words.

A line starts with a single `start` pulse while the block is idle. The pulse also captures the source width, the destination width, the signed start position and the increment. Pixels enter on a valid/ready stream. `in_ready` is high only while source pixels are still owed. Results leave on a second valid/ready stream. When `out_ready` is low, the current result and `out_valid` hold until it is taken, so a stalled consumer loses nothing. The input stream never stalls the output, because the two phases do not overlap.

Top module: `scl_hscale`

## Requirements
- R1: After reset the block is idle (`busy`, `in_ready` and `out_valid` are low). Every stored phase holds the identity filter: tap 3 is 1024 and the other taps are 0.
- R2: A `start` pulse while idle captures the configuration. The block then accepts exactly `src_wm1`+1 pixels, with `in_ready` high only during that time, and emits exactly `dst_wm1`+1 pixels. After that it returns to idle. A `start` pulse while busy is ignored.
- R3: Destination pixel k is computed at position P = `start_pos` + k·`phase_inc`, a signed value with 13 fractional bits. The centre source index is floor(P / 8192), and the phase is bits [12:9] of P.
- R4: Tap j (0..6) reads source index centre+j−3. An index below 0 reads pixel 0, and an index above `src_wm1` reads the last pixel.
- R5: Phases 0..8 use stored phase p directly. Phase 16−k (k = 1..7) uses stored phase k with tap j taking that phase's tap 6−j.
- R6: A write to address a, with a[3:0] = phase p and a[5:4] = word w, updates only the bits of phase p that word w carries. Coefficients are 12-bit two's complement.
  - w=0 sets tap 0 from data[27:16], tap 1 from data[15:4], and tap 2 bits [11:8] from data[3:0].
  - w=1 sets tap 2 bits [7:0] from data[27:20], tap 3 from data[19:8], and tap 4 bits [11:4] from data[7:0].
  - w=2 sets tap 4 bits [3:0] from data[27:24], tap 5 from data[23:12], and tap 6 from data[11:0].
- R7: A write whose phase field is above 8, or whose word field is 3, changes no coefficient.
- R8: The output is the signed sum S of coefficient × pixel, computed as floor((S+512)/1024) and clamped to 0..255.
- R9: A weight write that arrives while busy is held, and it takes effect in the first idle cycle after the line. Only one write is held: a later write during the same line replaces it.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R11: With the identity filter, `phase_inc` = 8192 and `start_pos` = 0, each output pixel equals the input pixel at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (taken only while idle) |
| src_wm1 | input | 12 | Source width minus one |
| dst_wm1 | input | 12 | Destination width minus one |
| start_pos | input | 19 | Signed start position, 13 fractional bits |
| phase_inc | input | 16 | Position step per output, 13 fractional bits |
| cfg_we | input | 1 | Weight write strobe |
| cfg_addr | input | 6 | Weight word address: [5:4] word, [3:0] phase |
| cfg_wdata | input | 32 | Weight write data |
| in_valid | input | 1 | Source pixel valid |
| in_data | input | 8 | Source pixel |
| in_ready | output | 1 | Block accepts a source pixel |
| out_valid | output | 1 | Destination pixel valid |
| out_data | output | 8 | Destination pixel |
| out_ready | input | 1 | Consumer accepts the destination pixel |
| busy | output | 1 | Line in progress |

## Verification
Each destination pixel depends on the accumulator, the phase fold, the edge clamp and the weight bank. A wrong value in any of these shows at the output ports on the very handshake that uses it. A drifted accumulator corrupts every later pixel of the line. A bad fold only hits phases 9 to 15, and a bad clamp only hits pixels near the line ends, so the sweeps step through all 16 phases and push positions past both ends. A held weight write landing at the wrong moment changes the pixels of the line it should not touch, or of the line after it. Miscounted handshakes show within one cycle as a missing or extra `in_ready` or `out_valid`.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int COEF_W   = 12;
  localparam int TAPS     = 7;
  localparam int CTR      = TAPS / 2;
  localparam int PHASES   = 16;
  localparam int PH_BITS  = 4;
  localparam int STORED   = PHASES / 2 + 1;
  localparam int UNITY    = 1 << (COEF_W - 2);
  localparam int CADDR_W  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} scl_state_t;

  typedef struct packed {
    logic [CADDR_W-1:0] addr;
    logic [27:0]        data;
  } cfg_wr_t;
endpackage

// File: rtl/scl_coef_bank.sv
module scl_coef_bank import scl_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic                    wr_en,
  input  cfg_wr_t                 wr,
  input  logic [PH_BITS-1:0]      phase,
  output logic [TAPS*COEF_W-1:0]  coefs_o
);
  logic [COEF_W-1:0] coef_q [STORED][TAPS];
  cfg_wr_t held_q;
  logic    held_v_q;
  logic    app_en;
  cfg_wr_t app;
  logic [1:0] bank;
  logic [PH_BITS-1:0] wph;
  logic hit;

  // A held write goes first; a fresh write in that cycle is held in turn.
  always_comb begin
    app_en = 1'b0;
    app    = wr;
    if (!busy) begin
      if (held_v_q) begin
        app_en = 1'b1;
        app    = held_q;
      end else if (wr_en) begin
        app_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v_q <= 1'b0;
      held_q   <= '0;
    end else if (wr_en && (busy || held_v_q)) begin
      held_v_q <= 1'b1;
      held_q   <= wr;
    end else if (!busy && held_v_q) begin
      held_v_q <= 1'b0;
    end
  end

  assign bank = app.addr[5:4];
  assign wph  = app.addr[3:0];
  assign hit  = app_en && (wph < PH_BITS'(STORED)) && (bank != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < STORED; p++)
        for (int j = 0; j < TAPS; j++)
          coef_q[p][j] <= (j == CTR) ? COEF_W'(UNITY) : '0;
    end else if (hit) begin
      case (bank)
        2'd0: begin
          coef_q[wph][0]        <= app.data[27:16];
          coef_q[wph][1]        <= app.data[15:4];
          coef_q[wph][2][11:8]  <= app.data[3:0];
        end
        2'd1: begin
          coef_q[wph][2][7:0]   <= app.data[27:20];
          coef_q[wph][3]        <= app.data[19:8];
          coef_q[wph][4][11:4]  <= app.data[7:0];
        end
        default: begin
          coef_q[wph][4][3:0]   <= app.data[27:24];
          coef_q[wph][5]        <= app.data[23:12];
          coef_q[wph][6]        <= app.data[11:0];
        end
      endcase
    end
  end

  // Fold phases above the midpoint onto stored ones, taps reversed.
  logic               rev;
  logic [PH_BITS-1:0] src_ph;
  assign rev    = phase > PH_BITS'(STORED - 1);
  assign src_ph = rev ? PH_BITS'(5'(PHASES) - {1'b0, phase}) : phase;

  for (genvar j = 0; j < TAPS; j++) begin : g_sel
    assign coefs_o[j*COEF_W +: COEF_W] = rev ? coef_q[src_ph][TAPS-1-j]
                                             : coef_q[src_ph][j];
  end
endmodule

// File: rtl/scl_line_buf.sv
module scl_line_buf import scl_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int W_BITS = 12,
  parameter int MAX_W  = 64,
  parameter int CI_W   = 17
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [$clog2(MAX_W)-1:0] wr_idx,
  input  logic [PIX_W-1:0]       wr_data,
  input  logic signed [CI_W-1:0] centre,
  input  logic [W_BITS-1:0]      last,
  output logic [TAPS*PIX_W-1:0]  pix_o
);
  localparam int LA_W = $clog2(MAX_W);

  logic [PIX_W-1:0] mem_q [MAX_W];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  logic signed [CI_W:0] last_s;
  assign last_s = $signed({{(CI_W+1-W_BITS){1'b0}}, last});

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    localparam logic signed [CI_W:0] OFS = (CI_W+1)'(j - CTR);
    logic signed [CI_W:0] t;
    logic [LA_W-1:0]      sel;
    always_comb begin
      t = $signed({centre[CI_W-1], centre}) + OFS;
      if (t < 0)           sel = '0;
      else if (t > last_s) sel = last[LA_W-1:0];
      else                 sel = t[LA_W-1:0];
    end
    assign pix_o[j*PIX_W +: PIX_W] = mem_q[sel];
  end
endmodule

// File: rtl/scl_mac.sv
module scl_mac import scl_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic [TAPS*COEF_W-1:0] coefs,
  input  logic [TAPS*PIX_W-1:0]  pix,
  output logic [PIX_W-1:0]       res
);
  localparam int SHIFT = COEF_W - 2;
  localparam int SUM_W = COEF_W + PIX_W + 4;
  localparam logic signed [SUM_W-1:0] RND_C   = SUM_W'(1 << (SHIFT - 1));
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] acc, rnd, c_e, p_e;

  always_comb begin
    acc = '0;
    for (int j = 0; j < TAPS; j++) begin
      c_e = SUM_W'($signed(coefs[j*COEF_W +: COEF_W]));
      p_e = SUM_W'({1'b0, pix[j*PIX_W +: PIX_W]});
      acc = acc + c_e * p_e;
    end
    rnd = (acc + RND_C) >>> SHIFT;
    if (rnd < 0)            res = '0;
    else if (rnd > PIX_MAX) res = '1;
    else                    res = rnd[PIX_W-1:0];
  end
endmodule

// File: rtl/scl_hscale.sv
module scl_hscale import scl_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int W_BITS = 12,
  parameter int MAX_W  = 64,
  parameter int INC_W  = 16,
  parameter int POS_W  = 19,
  parameter int FRAC   = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [W_BITS-1:0]        src_wm1,
  input  logic [W_BITS-1:0]        dst_wm1,
  input  logic signed [POS_W-1:0]  start_pos,
  input  logic [INC_W-1:0]         phase_inc,
  input  logic                     cfg_we,
  input  logic [CADDR_W-1:0]       cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_data,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_data,
  input  logic                     out_ready,
  output logic                     busy
);
  localparam int ACC_W = W_BITS + INC_W + 2;
  localparam int CI_W  = ACC_W - FRAC;
  localparam int LA_W  = $clog2(MAX_W);

  scl_state_t               state_q;
  logic [W_BITS-1:0]        src_q, dst_q, icnt_q, ocnt_q;
  logic [INC_W-1:0]         inc_q;
  logic signed [POS_W-1:0]  spos_q;
  logic signed [ACC_W-1:0]  acc_q;

  logic unused_wr_hi;
  logic unused_acc_lo;
  assign unused_wr_hi  = ^cfg_wdata[31:28];
  assign unused_acc_lo = ^acc_q[FRAC-PH_BITS-1:0];

  assign busy      = state_q != ST_IDLE;
  assign in_ready  = state_q == ST_LOAD;
  assign out_valid = state_q == ST_RUN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      inc_q   <= '0;
      spos_q  <= '0;
      icnt_q  <= '0;
      ocnt_q  <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          src_q   <= src_wm1;
          dst_q   <= dst_wm1;
          inc_q   <= phase_inc;
          spos_q  <= start_pos;
          icnt_q  <= '0;
          ocnt_q  <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (in_valid) begin
          icnt_q <= icnt_q + 1'b1;
          if (icnt_q == src_q) begin
            acc_q   <= ACC_W'(spos_q);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (out_ready) begin
          acc_q  <= acc_q + $signed({{(ACC_W-INC_W){1'b0}}, inc_q});
          ocnt_q <= ocnt_q + 1'b1;
          if (ocnt_q == dst_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [TAPS*COEF_W-1:0] coefs;
  logic [TAPS*PIX_W-1:0]  taps;
  cfg_wr_t                wr;
  assign wr = '{addr: cfg_addr, data: cfg_wdata[27:0]};

  scl_coef_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .wr_en   (cfg_we),
    .wr      (wr),
    .phase   (acc_q[FRAC-1 -: PH_BITS]),
    .coefs_o (coefs)
  );

  scl_line_buf #(.PIX_W(PIX_W), .W_BITS(W_BITS), .MAX_W(MAX_W), .CI_W(CI_W)) u_line (
    .clk     (clk),
    .wr_en   (in_valid && in_ready),
    .wr_idx  (icnt_q[LA_W-1:0]),
    .wr_data (in_data),
    .centre  (acc_q[ACC_W-1:FRAC]),
    .last    (src_q),
    .pix_o   (taps)
  );

  scl_mac #(.PIX_W(PIX_W)) u_mac (
    .coefs (coefs),
    .pix   (taps),
    .res   (out_data)
  );
endmodule

// File: rtl/scl_hscale_chk.sv
module scl_hscale_chk #(
  parameter int PIX_W  = 8,
  parameter int W_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [W_BITS-1:0] src_wm1,
  input logic [W_BITS-1:0] dst_wm1,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_data,
  input logic              busy
);
  logic [W_BITS-1:0] src_l, dst_l, ocnt;
  logic [W_BITS:0]   icnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_l <= '0; dst_l <= '0; icnt <= '0; ocnt <= '0;
    end else if (start && !busy) begin
      src_l <= src_wm1; dst_l <= dst_wm1; icnt <= '0; ocnt <= '0;
    end else begin
      if (in_valid && in_ready)   icnt <= icnt + 1'b1;
      if (out_valid && out_ready) ocnt <= ocnt + 1'b1;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));

  p_input_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (icnt <= {1'b0, src_l}));

  p_out_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (icnt == {1'b0, src_l} + 1'b1));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && ocnt == dst_l) |=> !busy);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && out_ready && ocnt == dst_l)) |=> busy);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind scl_hscale scl_hscale_chk #(.PIX_W(PIX_W), .W_BITS(W_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_wm1(src_wm1), .dst_wm1(dst_wm1),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .busy(busy)
);

// File: tb/tb_scl_hscale.sv
module tb_scl_hscale;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] src_wm1 = '0, dst_wm1 = '0;
  logic signed [18:0] start_pos = '0;
  logic [15:0] phase_inc = '0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_ready, busy;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int m_coef [9][7];
  int stage [7];
  logic [7:0] pix_a [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_hscale dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_wm1(src_wm1), .dst_wm1(dst_wm1),
    .start_pos(start_pos), .phase_inc(phase_inc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_out(int k, int sw, int st, int inc);
    longint pos, ip, idx, sum, r;
    int ph, c;
    pos = longint'(st) + longint'(k) * longint'(inc);
    ip  = pos >>> 13;
    ph  = int'((pos >>> 9) & 15);
    sum = 0;
    for (int j = 0; j < 7; j++) begin
      idx = ip + j - 3;
      if (idx < 0) idx = 0;
      if (idx > sw - 1) idx = sw - 1;
      c = (ph <= 8) ? m_coef[ph][j] : m_coef[16-ph][6-j];
      sum += longint'(c) * longint'(pix_a[idx]);
    end
    r = (sum + 512) >>> 10;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int word_a(int c0, int c1, int c2);
    return ((c0 & 4095) << 16) | ((c1 & 4095) << 4) | ((c2 >> 8) & 15);
  endfunction
  function automatic int word_b(int c2, int c3, int c4);
    return ((c2 & 255) << 20) | ((c3 & 4095) << 8) | ((c4 >> 4) & 255);
  endfunction
  function automatic int word_c(int c4, int c5, int c6);
    return ((c4 & 15) << 24) | ((c5 & 4095) << 12) | (c6 & 4095);
  endfunction

  // R6: stage[] packed into three words, model follows.
  task automatic load_phase(input int p);
    wr(p,      word_a(stage[0], stage[1], stage[2]));
    wr(p + 16, word_b(stage[2], stage[3], stage[4]));
    wr(p + 32, word_c(stage[4], stage[5], stage[6]));
    for (int j = 0; j < 7; j++) m_coef[p][j] = stage[j];
  endtask

  task automatic load_set(input int kind);
    for (int p = 0; p < 9; p++) begin
      for (int j = 0; j < 7; j++) begin
        if (kind == 0) stage[j] = ((p * 53 + j * 29 + 7) % 700) - 200;
        else           stage[j] = -((p * 41 + j * 17) % 600) + ((j == 3) ? 900 : 0);
      end
      load_phase(p);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 64; i++) pix_a[i] = 8'((i * 73 + seed * 29 + 11) % 256);
    pix_a[1] = 8'd0; pix_a[2] = 8'd255;
  endtask

  // mid: 1 = two writes while busy (second one kept) plus a stray start
  task automatic run_line(input int sw, input int dw, input int st, input int inc,
                          input string req, input int mid);
    int ii, oi, cyc, e;
    @(negedge clk);
    src_wm1 = 12'(sw - 1); dst_wm1 = 12'(dw - 1);
    start_pos = 19'(st); phase_inc = 16'(inc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ii = 0; oi = 0; cyc = 0;
    while (oi < dw && cyc < 4000) begin
      in_valid  = (cyc % 3 != 1);
      in_data   = (ii < sw && ii < 64) ? pix_a[ii] : 8'hA5;
      out_ready = (cyc % 4 != 2);
      cfg_we    = 1'b0;
      if (mid == 1 && oi == 1 && out_valid) begin
        cfg_we = 1'b1; cfg_addr = 6'd32; cfg_wdata = 32'h0FFF_FFFF;
      end
      if (mid == 1 && oi == 3 && out_valid) begin
        cfg_we = 1'b1; cfg_addr = 6'd32;
        cfg_wdata = word_c(m_coef[0][4], 77, -5);
        start = 1'b1; src_wm1 = 12'd3; dst_wm1 = 12'd2; start_pos = 19'd40000;
      end
      #1;
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        e = exp_out(oi, sw, st, inc);
        chk(out_data == 8'(e), req, out_data, e);
        oi++;
      end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(!busy && !out_valid, "R2 idle after line", int'(busy), 0);
    chk(ii == sw, "R2 input count", ii, sw);
    chk(oi == dw, "R2 output count", oi, dw);
  endtask

  function automatic int inc_of(int s, int d);
    return ((s << 13) + (d >> 1)) / d;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    out_ready = 1'b0;
    for (int p = 0; p < 9; p++)
      for (int j = 0; j < 7; j++) m_coef[p][j] = (j == 3) ? 1024 : 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !in_ready && !out_valid, "R1 reset idle", int'(busy), 0);
    rst_n = 1'b1;
    fill(1);
    // R11 / R1: identity bank out of reset, unity step
    run_line(24, 24, 0, 8192, "R11 identity copy", 0);
    for (int i = 0; i < 24; i++) chk(exp_out(i, 24, 0, 8192) == int'(pix_a[i]), "R11 model", exp_out(i, 24, 0, 8192), pix_a[i]);

    load_set(0);
    fill(2);
    run_line(20, 37, 0, inc_of(20, 37), "R3 upscale", 0);
    run_line(40, 17, -2048, inc_of(40, 17), "R4 downscale left edge", 0);
    run_line(16, 16, 0, 8192 + 512, "R5 all phases", 0);
    run_line(12, 12, -4096, 8192 - 512, "R5 reverse sweep", 0);
    run_line(10, 8, 11 * 8192, 1024, "R4 right edge", 0);

    load_set(1);
    fill(3);
    run_line(30, 30, 0, 8192 + 512, "R8 clamp", 0);
    run_line(18, 25, -8192, inc_of(18, 25), "R8 negative start", 0);

    // R7: writes to absent phases and the unused word field
    wr(9, 32'h0FFF_FFFF);
    wr(16 + 12, 32'h0FFF_FFFF);
    wr(48 + 1, 32'h0FFF_FFFF);
    wr(63, 32'h0123_4567);
    run_line(16, 16, 0, 8192 + 512, "R7 ignored writes", 0);

    // R9 / R2: held writes and a stray start during the line
    run_line(14, 10, 0, 8192, "R9 old weights during line", 1);
    m_coef[0][5] = 77; m_coef[0][6] = -5;
    run_line(14, 14, 0, 8192, "R9 held write applied", 0);
    run_line(9, 20, -2048, inc_of(9, 20), "R6 partial word update", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule